// File: doc/BRIEF.md
# Stream-to-Memory Ring Buffer Writer

This block takes a valid/ready word stream and writes every word into an external memory. The memory is reached through two channels. The command channel carries valid, ready, a write-enable bit and an address. The write-data channel carries valid, ready and the data word. Each accepted word goes to a slot of a ring in memory. The slot address is a fixed base offset plus the write pointer, and the write pointer comes from a separate pointer controller. That controller keeps the ring's fill level and reports whether there is room.

Only one word is in flight at a time. After both channels have taken the word, the block pulses the controller's write strobe for one cycle, and the controller then advances its pointer and level. When the controller reports no room, the block stops accepting input. The stream is therefore throttled by the level threshold and no words are lost. Once the ring has wrapped, new words overwrite the oldest slots in ring order.

Top module: `ring_stream_writer`

## Requirements
- R1: A word accepted while the controller's pointer is p is written at address BASE_ADDR + p. With a controller that wraps its pointer at the ring depth, word k lands at BASE_ADDR + (k mod depth).
- R2: While `ctl_writable` is low, `in_ready` is low and no new command is issued. The input word waits and is not dropped.
- R3: A word is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low while a command, a data beat or the write strobe of the previous word is still outstanding.
- R4: Every command carries `mem_cmd_we` = 1. While `mem_cmd_valid` is high and `mem_cmd_ready` is low, valid and address are held unchanged into the next cycle.
- R5: While `mem_wdata_valid` is high and `mem_wdata_ready` is low, valid and data are held unchanged into the next cycle.
- R6: `ctl_wr_strobe` is high for exactly one cycle per word, in the cycle right after the later of the two channel handshakes.
- R7: The two channels complete independently. The command may be taken first, the data may be taken first, or both may be taken in the same cycle, and the address and data stay paired in every case.
- R8: Out of reset, both channel valids and the write strobe are low.
- R9: When more words are written than the ring holds, later words overwrite earlier slots in wrap order. Each slot ends up holding the last word whose index mod depth equals the slot number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | DATA_W | Input word |
| ctl_wr_ptr | input | PTR_W | Controller's current write slot |
| ctl_writable | input | 1 | Controller has room (level below write threshold) |
| ctl_wr_strobe | output | 1 | One-cycle pulse per committed word |
| mem_cmd_valid | output | 1 | Command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | Write enable, always 1 |
| mem_cmd_addr | output | ADDR_W | Slot address |
| mem_wdata_valid | output | 1 | Data beat present |
| mem_wdata_ready | input | 1 | Memory takes the data beat |
| mem_wdata | output | DATA_W | Data beat |

## Verification
The command handshake and the data handshake may land on the same clock edge. When that happens, the block must see both as finished at once and raise the strobe exactly one cycle later. The bench provokes this with both readies held high. It then runs skewed patterns, where one channel waits three cycles, and a random pattern. The scoreboard pairs each captured address with its data and checks the strobe cycle by cycle against the later of the two handshakes. A second overlap is the controller's level reaching the threshold while a word is still waiting at the input. This is judged by confirming that no command appears until the bench frees a slot, and that the waiting word is then written intact.

// File: rtl/ringwr_pkg.sv
package ringwr_pkg;

  // Occupancy of one outgoing channel holding register.
  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_state_e;

endpackage

// File: rtl/rw_slot_addr.sv
module rw_slot_addr #(
  parameter int          ADDR_W    = 32,
  parameter int          PTR_W     = 5,
  parameter logic [63:0] BASE_ADDR = 64'd0
) (
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

  // Ring slot address: fixed base plus the controller's pointer.
  assign addr = BASE_W + ADDR_W'(ptr);

endmodule

// File: rtl/rw_hold_chan.sv
module rw_hold_chan
  import ringwr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] payload
);

  slot_state_e  st_q, st_d;
  logic [W-1:0] pay_q;
  logic         pay_en;

  // Next state: a held beat leaves on ready, a new beat enters on load.
  always_comb begin
    st_d   = st_q;
    pay_en = load;
    if (st_q == SLOT_HELD && ready) st_d = SLOT_FREE;
    if (load)                       st_d = SLOT_HELD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SLOT_FREE;
      pay_q <= '0;
    end else begin
      st_q <= st_d;
      if (pay_en) pay_q <= load_val;
    end
  end

  assign valid   = (st_q == SLOT_HELD);
  assign payload = pay_q;

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid); // R3

endmodule

// File: rtl/rw_issue_ctrl.sv
module rw_issue_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_ready,
  input  logic dat_valid,
  input  logic dat_ready,
  output logic busy,
  output logic word_done
);

  logic cmd_left, dat_left, finishing;
  logic done_q, done_d;

  // A word finishes in the cycle where nothing outstanding remains unaccepted.
  always_comb begin
    cmd_left  = cmd_valid & ~cmd_ready;
    dat_left  = dat_valid & ~dat_ready;
    finishing = (cmd_valid | dat_valid) & ~cmd_left & ~dat_left;
    done_d    = finishing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign word_done = done_q;
  // The strobe cycle also blocks input so the pointer can advance first.
  assign busy      = cmd_valid | dat_valid | done_q;

  AST_STROBE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(cmd_valid || dat_valid)); // R6
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6

endmodule

// File: rtl/ring_stream_writer.sv
module ring_stream_writer #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          PTR_W     = 5,
  parameter logic [63:0] BASE_ADDR = 64'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [PTR_W-1:0]  ctl_wr_ptr,
  input  logic              ctl_writable,
  output logic              ctl_wr_strobe,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wdata_valid,
  input  logic              mem_wdata_ready,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int CMD_W = ADDR_W + 1;

  logic [ADDR_W-1:0] slot_addr;
  logic [CMD_W-1:0]  cmd_load, cmd_held;
  logic              busy, accept;

  rw_slot_addr #(
    .ADDR_W   (ADDR_W),
    .PTR_W    (PTR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_addr (
    .ptr (ctl_wr_ptr),
    .addr(slot_addr)
  );

  assign in_ready = ctl_writable & ~busy;
  assign accept   = in_valid & in_ready;
  assign cmd_load = {1'b1, slot_addr};

  rw_hold_chan #(.W(CMD_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(cmd_load),
    .ready   (mem_cmd_ready),
    .valid   (mem_cmd_valid),
    .payload (cmd_held)
  );

  rw_hold_chan #(.W(DATA_W)) u_dat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(in_data),
    .ready   (mem_wdata_ready),
    .valid   (mem_wdata_valid),
    .payload (mem_wdata)
  );

  assign mem_cmd_we   = cmd_held[CMD_W-1];
  assign mem_cmd_addr = cmd_held[ADDR_W-1:0];

  rw_issue_ctrl u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(mem_cmd_valid),
    .cmd_ready(mem_cmd_ready),
    .dat_valid(mem_wdata_valid),
    .dat_ready(mem_wdata_ready),
    .busy     (busy),
    .word_done(ctl_wr_strobe)
  );

  AST_SLOT_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_cmd_addr == ADDR_W'(BASE_ADDR) + ADDR_W'($past(ctl_wr_ptr))); // R1
  AST_NO_ISSUE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_writable && !mem_cmd_valid && !mem_wdata_valid) |=> !mem_cmd_valid); // R2
  AST_ACCEPT_LOADS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_cmd_valid && mem_wdata_valid); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=> mem_cmd_valid && mem_cmd_we && $stable(mem_cmd_addr)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wdata_valid && !mem_wdata_ready) |=> mem_wdata_valid && $stable(mem_wdata)); // R5

endmodule

// File: tb/ring_stream_writer_test.sv
`timescale 1ns/100ps
module ring_stream_writer_test;

  localparam int PTR_W  = 5;
  localparam int DEPTH  = 20;
  localparam int THRESH = 12;
  localparam int BASE   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [PTR_W-1:0] ptr;
  logic        ctl_writable;
  logic        ctl_wr_strobe;
  logic        mem_cmd_valid, mem_cmd_ready, mem_cmd_we;
  logic [31:0] mem_cmd_addr;
  logic        mem_wdata_valid, mem_wdata_ready;
  logic [31:0] mem_wdata;

  always #2.5 clk = ~clk;

  ring_stream_writer #(
    .DATA_W(32), .ADDR_W(32), .PTR_W(PTR_W), .BASE_ADDR(64'd8)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ctl_wr_ptr(ptr), .ctl_writable(ctl_writable), .ctl_wr_strobe(ctl_wr_strobe),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr),
    .mem_wdata_valid(mem_wdata_valid), .mem_wdata_ready(mem_wdata_ready),
    .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Pointer controller model: wraps at DEPTH, room while level < THRESH.
  int   level;
  logic rel_req;
  assign ctl_writable = (level < THRESH);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      level <= 0;
    end else begin
      if (ctl_wr_strobe) ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      level <= level + (ctl_wr_strobe ? 1 : 0) - ((rel_req && level > 0) ? 1 : 0);
    end
  end

  // Scoreboard state
  logic [63:0] exp_q[$];
  logic [31:0] mem     [0:63];
  logic [31:0] exp_mem [0:63];
  int wcount = 0;
  int n_cmd = 0;
  int n_strobe = 0;
  int rmode = 0;
  int cmd_dly = 0, dat_dly = 0;

  // Memory-side readiness driver and monitor.
  int   cw = 0, dw = 0;
  bit   got_c = 0, got_d = 0, strobe_exp = 0;
  bit   hold_c = 0, hold_d = 0;
  logic [31:0] cap_a, cap_d, hold_a, hold_v;

  always begin
    @(negedge clk);
    if (!mem_cmd_valid) begin cw = 0; mem_cmd_ready = 1'b0; end
    else begin
      mem_cmd_ready = (rmode == 3) ? ($urandom_range(0, 1) == 1) : (cw >= cmd_dly);
      cw++;
    end
    if (!mem_wdata_valid) begin dw = 0; mem_wdata_ready = 1'b0; end
    else begin
      mem_wdata_ready = (rmode == 3) ? ($urandom_range(0, 1) == 1) : (dw >= dat_dly);
      dw++;
    end
    #1;
    if (rst_n) begin
      if (strobe_exp || ctl_wr_strobe)
        check(ctl_wr_strobe == strobe_exp, "R6", "strobe cycle", ctl_wr_strobe, strobe_exp);
      if (ctl_wr_strobe) n_strobe++;
      strobe_exp = 0;
      if (in_valid && !ctl_writable)
        check(!in_ready, "R2", "ready while not writable", in_ready, 0);
      if (in_valid && (mem_cmd_valid || mem_wdata_valid || ctl_wr_strobe))
        check(!in_ready, "R3", "ready while word outstanding", in_ready, 0);
      if (hold_c) check(mem_cmd_valid && mem_cmd_addr == hold_a, "R4", "command hold",
                        mem_cmd_addr, hold_a);
      if (hold_d) check(mem_wdata_valid && mem_wdata == hold_v, "R5", "data hold",
                        mem_wdata, hold_v);
      hold_c = mem_cmd_valid && !mem_cmd_ready;
      hold_a = mem_cmd_addr;
      hold_d = mem_wdata_valid && !mem_wdata_ready;
      hold_v = mem_wdata;
      if (mem_cmd_valid && mem_cmd_ready) begin
        check(mem_cmd_we == 1'b1, "R4", "write enable", mem_cmd_we, 1);
        got_c = 1; cap_a = mem_cmd_addr; n_cmd++;
      end
      if (mem_wdata_valid && mem_wdata_ready) begin
        got_d = 1; cap_d = mem_wdata;
      end
      if (got_c && got_d) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "write with no accepted word", {cap_a, cap_d}, 0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(cap_a == e[63:32], "R1", "slot address (R7 pairing)", cap_a, e[63:32]);
          check(cap_d == e[31:0], "R7", "paired data", cap_d, e[31:0]);
        end
        mem[cap_a[5:0]] = cap_d;
        got_c = 0; got_d = 0;
        strobe_exp = 1;
      end
    end
  end

  task automatic send_word(input logic [31:0] d);
    in_valid = 1'b1;
    in_data  = d;
    while (1) begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back({32'(BASE + (wcount % DEPTH)), d});
    exp_mem[BASE + (wcount % DEPTH)] = d;
    wcount++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic release_one();
    while (level == 0) @(negedge clk);
    rel_req = 1'b1;
    @(negedge clk);
    rel_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R3", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; rel_req = 1'b0;
    mem_cmd_ready = 1'b0; mem_wdata_ready = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(!mem_cmd_valid, "R8", "cmd valid in reset", mem_cmd_valid, 0);
    check(!mem_wdata_valid, "R8", "data valid in reset", mem_wdata_valid, 0);
    check(!ctl_wr_strobe, "R8", "strobe in reset", ctl_wr_strobe, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Four ready patterns: same cycle, command first, data first, random (R7).
    for (int m = 0; m < 4; m++) begin
      rmode = m;
      cmd_dly = (m == 2) ? 3 : 0;
      dat_dly = (m == 1) ? 3 : 0;
      for (int k = 0; k < 8; k++) begin
        send_word(32'h9E3779B1 * (m * 8 + k + 1) + 32'(m));
        release_one();
      end
    end

    // Fill to the threshold with no slots freed (R2).
    rmode = 0; cmd_dly = 0; dat_dly = 0;
    for (int k = 0; k < THRESH; k++) send_word(32'hC0DE0000 + 32'(k));
    repeat (6) @(negedge clk);
    begin
      int cmd_before;
      cmd_before = n_cmd;
      in_valid = 1'b1; in_data = 32'h5EED5EED;
      repeat (15) @(negedge clk);
      #1;
      check(n_cmd == cmd_before, "R2", "command issued while full", n_cmd, cmd_before);
      check(!mem_cmd_valid, "R2", "cmd valid while full", mem_cmd_valid, 0);
    end
    @(negedge clk);
    release_one();
    send_word(32'h5EED5EED);
    repeat (12) @(negedge clk);

    check(exp_q.size() == 0, "R6", "words left unwritten", exp_q.size(), 0);
    check(n_strobe == wcount, "R6", "strobe count", n_strobe, wcount);
    for (int s = 0; s < DEPTH; s++)
      check(mem[BASE + s] == exp_mem[BASE + s], "R9", "wrapped slot content",
            mem[BASE + s], exp_mem[BASE + s]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule